// File: doc/BRIEF.md
# Latency-Interleaved Multiply-Accumulate Element

This block is a single processing element that forms dot products of a streamed feature vector against L filters at the same time. The adder feeding the accumulator is modelled with a fixed latency of L cycles. A single accumulator would therefore wait L cycles between terms. Instead, L independent partial sums circulate through a ring of L registers. Each sum comes back to the adder exactly when the next term for its filter arrives. The adder takes one new term every cycle and never waits on its own result.

The input stream is feature-major with filters innermost. One feature value is presented on L consecutive accepted beats, and each of those beats carries the weight of filter 0, 1, ..., L-1 in turn. A start flag marks every beat of the first feature of a dot product. On those beats a multiplexer at the ring input takes the bias instead of the returning partial sum. A last flag marks every beat of the final feature. On those beats the completed sum of the slot leaves on the output, tagged with its filter index. Arithmetic is signed fixed point: narrow inputs, a full-width product and a wider accumulator.

Top module: `imac_pe`

## Requirements
- R1: While the internal reset is active, out_valid, out_sum and out_filt are all zero. The first beat accepted after reset belongs to filter slot 0.
- R2: A beat is accepted in every cycle where in_valid is high. Each accepted beat belongs to filter slot (number of accepted beats since reset) mod L, and out_filt reports the slot of the result it carries.
- R3: On an accepted beat with in_first=1, the slot's sum starts from the sign-extended in_bias. in_bias has no effect on beats with in_first=0. By convention, in_first is high on all L beats of the first feature and in_last is high on all L beats of the final feature.
- R4: An accepted beat with in_last=1 produces an out_valid pulse in the next cycle. That pulse carries out_sum = bias + sum of feature*weight over the dot product for that slot, and out_filt = the slot. The L results of one dot product leave in filter order 0 to L-1.
- R5: One beat is accepted in every cycle without stalling. A new dot product's first group may directly follow the previous final group. With no valid gaps, the L results of a dot product appear on L consecutive cycles.
- R6: A cycle with in_valid low advances nothing. in_first, in_last, in_feat, in_wgt and in_bias are ignored. out_valid is low in the next cycle, and out_sum and out_filt hold their values.
- R7: Feature, weight and bias are signed two's complement. Products keep full width, and accumulation wraps modulo 2^ACC_W.
- R8: A one-feature dot product, with in_first and in_last both high on the same group, yields bias + feature*weight for each slot.
- R9: out_valid is never high except in the cycle after an accepted beat with in_last=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Beat present this cycle |
| in_first | input | 1 | Beat belongs to the first feature of a dot product |
| in_last | input | 1 | Beat belongs to the final feature of a dot product |
| in_feat | input | FEAT_W | Signed feature value |
| in_wgt | input | WGT_W | Signed weight of the current filter slot |
| in_bias | input | BIAS_W | Signed bias of the current filter slot |
| out_valid | output | 1 | Finished dot product present |
| out_filt | output | max(1, clog2(LAT)) | Filter slot of the finished result |
| out_sum | output | ACC_W | Signed finished dot product |

## Verification
The bench builds the element with LAT=3 and the default 16-bit inputs and 32-bit accumulator. A ring depth that is not a power of two makes the slot counter wrap explicitly rather than by truncation. Dot products made only of -32768 terms drive the accumulator past 2^31, which brings the modulo wrap within reach. Random valid gaps with garbage data and flags, reset in the middle of a group, and single-feature products exercise stalling, bias selection and slot realignment.

// File: rtl/imac_pkg.sv
package imac_pkg;

  localparam int DEF_LAT    = 4;
  localparam int DEF_DATA_W = 16;
  localparam int DEF_ACC_W  = 32;

  // Next filter slot in a ring of lat entries.
  function automatic int slot_after(int cur, int lat);
    return (cur >= lat - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/imac_slot_seq.sv
module imac_slot_seq #(
  parameter int LAT   = imac_pkg::DEF_LAT,
  parameter int IDX_W = (LAT > 1) ? $clog2(LAT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] slot
);

  logic [IDX_W-1:0] slot_q;
  logic [IDX_W-1:0] slot_d;

  always_comb begin
    slot_d = slot_q;
    if (adv) begin
      slot_d = IDX_W'(imac_pkg::slot_after(int'(slot_q), LAT));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else begin
      slot_q <= slot_d;
    end
  end

  assign slot = slot_q;

  // R2: slot index stays inside the ring
  a_r2_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot_q) < LAT);

endmodule

// File: rtl/imac_mac_stage.sv
module imac_mac_stage #(
  parameter int FEAT_W = imac_pkg::DEF_DATA_W,
  parameter int WGT_W  = imac_pkg::DEF_DATA_W,
  parameter int BIAS_W = imac_pkg::DEF_DATA_W,
  parameter int ACC_W  = imac_pkg::DEF_ACC_W
) (
  input  logic                     first,
  input  logic signed [FEAT_W-1:0] feat,
  input  logic signed [WGT_W-1:0]  wgt,
  input  logic signed [BIAS_W-1:0] bias,
  input  logic signed [ACC_W-1:0]  loop_in,
  output logic signed [ACC_W-1:0]  sum
);

  localparam int PROD_W = FEAT_W + WGT_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  bias_ext;
  logic signed [ACC_W-1:0]  base;

  assign prod     = feat * wgt;
  assign prod_ext = ACC_W'(prod);
  assign bias_ext = ACC_W'(bias);

  // Seed select: bias on the opening group, returning partial sum otherwise.
  always_comb begin
    if (first) begin
      base = bias_ext;
    end else begin
      base = loop_in;
    end
  end

  assign sum = base + prod_ext;

endmodule

// File: rtl/imac_ring.sv
module imac_ring #(
  parameter int LAT   = imac_pkg::DEF_LAT,
  parameter int ACC_W = imac_pkg::DEF_ACC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] d,
  output logic signed [ACC_W-1:0] tail
);

  logic signed [ACC_W-1:0] stage_q [LAT];
  logic signed [ACC_W-1:0] stage_d [LAT];

  always_comb begin
    stage_d[0] = d;
    for (int i = 1; i < LAT; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin
        stage_q[i] <= '0;
      end
    end else if (en) begin
      for (int i = 0; i < LAT; i++) begin
        stage_q[i] <= stage_d[i];
      end
    end
  end

  assign tail = stage_q[LAT-1];

endmodule

// File: rtl/imac_pe.sv
module imac_pe #(
  parameter int LAT    = imac_pkg::DEF_LAT,
  parameter int FEAT_W = imac_pkg::DEF_DATA_W,
  parameter int WGT_W  = imac_pkg::DEF_DATA_W,
  parameter int BIAS_W = imac_pkg::DEF_DATA_W,
  parameter int ACC_W  = imac_pkg::DEF_ACC_W,
  localparam int IDX_W = (LAT > 1) ? $clog2(LAT) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_first,
  input  logic                     in_last,
  input  logic signed [FEAT_W-1:0] in_feat,
  input  logic signed [WGT_W-1:0]  in_wgt,
  input  logic signed [BIAS_W-1:0] in_bias,
  output logic                     out_valid,
  output logic [IDX_W-1:0]         out_filt,
  output logic signed [ACC_W-1:0]  out_sum
);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q;
  logic rst_sync_q;
  logic rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign rst_ni = rst_sync_q;

  logic [IDX_W-1:0]        slot;
  logic signed [ACC_W-1:0] ring_tail;
  logic signed [ACC_W-1:0] mac_sum;

  imac_slot_seq #(.LAT(LAT), .IDX_W(IDX_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_ni),
    .adv   (in_valid),
    .slot  (slot)
  );

  imac_mac_stage #(
    .FEAT_W (FEAT_W),
    .WGT_W  (WGT_W),
    .BIAS_W (BIAS_W),
    .ACC_W  (ACC_W)
  ) u_mac (
    .first   (in_first),
    .feat    (in_feat),
    .wgt     (in_wgt),
    .bias    (in_bias),
    .loop_in (ring_tail),
    .sum     (mac_sum)
  );

  imac_ring #(.LAT(LAT), .ACC_W(ACC_W)) u_ring (
    .clk   (clk),
    .rst_n (rst_ni),
    .en    (in_valid),
    .d     (mac_sum),
    .tail  (ring_tail)
  );

  // Output stage: next-state logic, then registers.
  logic                    done_beat;
  logic                    out_valid_q;
  logic                    out_valid_d;
  logic [IDX_W-1:0]        out_filt_q;
  logic [IDX_W-1:0]        out_filt_d;
  logic signed [ACC_W-1:0] out_sum_q;
  logic signed [ACC_W-1:0] out_sum_d;

  assign done_beat = in_valid & in_last;

  always_comb begin
    out_valid_d = done_beat;
    out_filt_d  = out_filt_q;
    out_sum_d   = out_sum_q;
    if (done_beat) begin
      out_filt_d = slot;
      out_sum_d  = mac_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_filt_q  <= '0;
      out_sum_q   <= '0;
    end else begin
      out_valid_q <= out_valid_d;
      out_filt_q  <= out_filt_d;
      out_sum_q   <= out_sum_d;
    end
  end

  assign out_valid = out_valid_q;
  assign out_filt  = out_filt_q;
  assign out_sum   = out_sum_q;

  // R9: a result only follows an accepted final-group beat
  a_r9_out_needs_last: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |-> $past(in_valid && in_last));

  // R6: an idle cycle leaves the output side untouched
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !in_valid |=> (!out_valid && $stable(out_sum) && $stable(out_filt)));

  // R4: back-to-back results walk the filter slots in order
  a_r4_filter_order: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && $past(out_valid)) |->
      ((int'($past(out_filt)) == LAT - 1) ? (int'(out_filt) == 0)
                                          : (int'(out_filt) == int'($past(out_filt)) + 1)));

endmodule

// File: tb/tb_imac_pe.sv
module tb_imac_pe;

  localparam int L  = 3;
  localparam int FW = 16;
  localparam int AW = 32;
  localparam int IW = 2;

  // Case table: {feature count, gap percent, value mode}
  // mode 0: small values, 1: full 16-bit range, 2: all -32768 (wrap, R7)
  localparam int NCASE = 8;
  localparam logic [23:0] CASES [NCASE] = '{
    {8'd1,  8'd0,  8'd0},   // R8 single feature
    {8'd5,  8'd0,  8'd0},
    {8'd8,  8'd0,  8'd1},
    {8'd6,  8'd30, 8'd0},   // R6 gaps
    {8'd4,  8'd50, 8'd1},
    {8'd10, 8'd0,  8'd2},   // R7 wrap
    {8'd3,  8'd0,  8'd1},
    {8'd7,  8'd20, 8'd1}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rst_n;
  logic                 in_valid, in_first, in_last;
  logic signed [FW-1:0] in_feat, in_wgt, in_bias;
  logic                 out_valid;
  logic [IW-1:0]        out_filt;
  logic signed [AW-1:0] out_sum;

  imac_pe #(.LAT(L), .FEAT_W(FW), .WGT_W(FW), .BIAS_W(FW), .ACC_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_feat(in_feat), .in_wgt(in_wgt), .in_bias(in_bias),
    .out_valid(out_valid), .out_filt(out_filt), .out_sum(out_sum)
  );

  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;
  longint t0 = 0;
  bit     done = 1'b0;
  int     exp_sum [$];
  int     exp_f [$];
  bit     exp_ng [$];

  always @(posedge clk) cyc++;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    int es, ef;
    bit ng;
    if (rst_n && out_valid && !done) begin
      if (exp_sum.size() == 0) begin
        chk(1'b0, "R9", "unexpected out_valid", 1, 0);
      end else begin
        es = exp_sum.pop_front();
        ef = exp_f.pop_front();
        ng = exp_ng.pop_front();
        chk(int'(out_filt) == ef, "R2/R4", "out_filt", out_filt, ef);
        chk(out_sum == es, "R3/R4/R7", "out_sum", out_sum, es);
        if (ef == 0) t0 = cyc;
        if (ef == L - 1 && ng) chk(cyc - t0 == L - 1, "R5", "result burst span", cyc - t0, L - 1);
      end
    end
  end

  function automatic logic signed [FW-1:0] gen(int mode);
    if (mode == 0) return FW'($urandom_range(200) - 100);
    if (mode == 1) return FW'($urandom);
    return 16'sh8000;
  endfunction

  task automatic idle_cycles(int gap);
    while (int'($urandom_range(99)) < gap) begin
      @(negedge clk);
      in_valid = 1'b0;                // R6: garbage on every other input
      in_first = 1'($urandom);
      in_last  = 1'b1;
      in_feat  = FW'($urandom);
      in_wgt   = FW'($urandom);
      in_bias  = FW'($urandom);
    end
  endtask

  task automatic run_case(int nfeat, int gap, int mode);
    int acc [L];
    logic signed [FW-1:0] f, w, b;
    for (int j = 0; j < nfeat; j++) begin
      f = gen(mode);
      for (int k = 0; k < L; k++) begin
        w = gen(mode);
        b = gen(mode);               // R3: bias on later groups must be ignored
        if (j == 0) acc[k] = int'(b) + int'(f) * int'(w);
        else        acc[k] = acc[k] + int'(f) * int'(w);
        if (j == nfeat - 1) begin
          exp_sum.push_back(acc[k]);
          exp_f.push_back(k);
          exp_ng.push_back(gap == 0);
        end
        idle_cycles(gap);
        @(negedge clk);
        in_valid = 1'b1;
        in_first = (j == 0);
        in_last  = (j == nfeat - 1);
        in_feat  = f;
        in_wgt   = w;
        in_bias  = b;
      end
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic drain(string req);
    repeat (L + 3) @(negedge clk);
    chk(exp_sum.size() == 0, req, "results outstanding", exp_sum.size(), 0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    in_feat = '0; in_wgt = '0; in_bias = '0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared in reset
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(out_sum == 0, "R1", "out_sum in reset", out_sum, 0);
    chk(out_filt == '0, "R1", "out_filt in reset", out_filt, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Table walk: dot products back to back (R5), then drain.
    for (int c = 0; c < NCASE; c++) begin
      run_case(int'(CASES[c][23:16]), int'(CASES[c][15:8]), int'(CASES[c][7:0]));
    end
    go_idle();
    drain("R4");

    // R6: idle cycles with in_last held high produce nothing
    in_last = 1'b1;
    in_first = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R6", "out_valid while idle", out_valid, 0);
    end
    in_last = 1'b0;
    in_first = 1'b0;

    // R1: reset in the middle of a group realigns to slot 0
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_first = 1'b1; in_last = 1'b0;
      in_feat = FW'($urandom); in_wgt = FW'($urandom); in_bias = FW'($urandom);
    end
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after mid-run reset", out_valid, 0);
    chk(out_sum == 0, "R1", "out_sum after mid-run reset", out_sum, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_case(1, 0, 1);               // R8 after reset, slots start at 0
    go_idle();
    drain("R1/R8");

    done = 1'b1;
    summary();
  end

endmodule